// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one bank of sixteen general-purpose pins behind a small register port. Each pin can drive out (through an output-enable and a data bit) or be sampled as an input. Sampled inputs pass through a synchroniser. A pin configured as an input can raise a sticky interrupt flag when it sees a chosen edge or holds a chosen level. A single summary interrupt line reports any flag whose mask bit is clear.

Software sets pin roles with the direction, output-data and alternate-select registers, and picks triggers per pin through three registers: trigger kind, edge polarity and level polarity. It services the interrupt by reading the latched flags and writing zeros to the bits it has handled. The register port is a single-cycle write strobe with a combinational read path.

Top module: `gpio_irq_bank`

Register offsets (addr): 0 direction, 1 output data, 2 pin level (read only), 3 alternate select, 4 interrupt mask, 5 trigger kind, 6 edge polarity, 7 level polarity, 8 latched flags. Offsets 9 to 15 are unmapped.

## Requirements
- R1: After reset every register reads zero except the interrupt mask, which reads 0xFFFF, and `irq` is low.
- R2: `pin_oe` follows the direction register (1 = output), `pin_out` follows the output-data register and `alt_sel` follows the alternate-select register. Each register reads back the value last written, one clock after the write.
- R3: Offset 2 returns the level of `pin_in` after two synchronising flops, so a pin change shows up in a read two rising edges after it is applied.
- R4: Only pins whose direction bit is 0 can set a latched flag. A pin configured as an output never sets its flag.
- R5: With trigger kind bit = 1 (edge), edge polarity bit = 1 latches on a rising edge and 0 latches on a falling edge of the synchronised pin. The flag is set on the rising clock edge after the synchronised value changes.
- R6: With trigger kind bit = 0 (level), level polarity bit = 1 latches while the pin is high and 0 latches while it is low. The flag is set again on every cycle that the condition holds, even right after a clear.
- R7: Latched flags are sticky. A write to offset 8 keeps flag bits where the written data has 1 and clears them where it has 0.
- R8: A trigger arriving in the same cycle as a clearing write to offset 8 leaves its flag set.
- R9: `irq` is high exactly when some latched flag has its mask bit at 0. A mask bit of 1 hides the flag from `irq` but does not stop or clear latching.
- R10: Writes to offset 2 and to offsets 9 to 15 change nothing. Reads of offsets 9 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register offset for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Pad output data |
| pin_oe | output | 16 | Pad output enable, 1 = drive |
| alt_sel | output | 16 | Alternate-function select per pin |
| irq | output | 1 | Summary interrupt |

## Verification
The bench looks for a clear that races a fresh edge. A design that gives the write priority would drop that event and read back zero. It checks that a level trigger re-latches right after a clear. A design that treats level like a one-shot edge would read zero there. It also checks that masking hides a flag without erasing it. A design that gates latching with the mask would lose the flag, and one that clears on any write rather than AND-clearing would wipe neighbouring flags during a partial clear. Toggling output-configured pins, and writing to the read-only and unmapped offsets, catch decode that lets those accesses leak into state.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int unsigned ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_DIR      = 4'd0,
        RA_DOUT     = 4'd1,
        RA_PINLVL   = 4'd2,
        RA_ALTSEL   = 4'd3,
        RA_MASK     = 4'd4,
        RA_TRIGKIND = 4'd5,
        RA_EDGEPOL  = 4'd6,
        RA_LVLPOL   = 4'd7,
        RA_LATCH    = 4'd8
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] lvl_now,
    input  logic [WIDTH-1:0] lvl_prev,
    input  logic [WIDTH-1:0] is_output,
    input  logic [WIDTH-1:0] edge_kind,
    input  logic [WIDTH-1:0] edge_pol,
    input  logic [WIDTH-1:0] lvl_pol,
    output logic [WIDTH-1:0] trig
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic went_up, went_down, edge_hit, level_hit;
        assign went_up   = lvl_now[i] & ~lvl_prev[i];
        assign went_down = ~lvl_now[i] & lvl_prev[i];
        assign edge_hit  = edge_pol[i] ? went_up : went_down;
        assign level_hit = (lvl_now[i] == lvl_pol[i]);
        assign trig[i]   = ~is_output[i] & (edge_kind[i] ? edge_hit : level_hit);
    end
endmodule

// File: rtl/gpio_flag_latch.sv
module gpio_flag_latch #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_wr,
    input  logic [WIDTH-1:0] keep_bits,
    input  logic [WIDTH-1:0] trig,
    output logic [WIDTH-1:0] flags
);
    logic [WIDTH-1:0] kept;

    always_comb begin
        kept = clr_wr ? (flags & keep_bits) : flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= kept | trig;
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  alt_sel,
    output logic              irq
);
    logic [NPINS-1:0] dir_q, dout_q, alt_q, mask_q, kind_q, epol_q, lpol_q;
    logic [NPINS-1:0] lvl_sync, lvl_prev_q, trig, stat_q;
    logic             clr_wr;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(lvl_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_prev_q <= '0;
        else        lvl_prev_q <= lvl_sync;
    end

    gpio_trig_detect #(.WIDTH(NPINS)) u_detect (
        .lvl_now(lvl_sync), .lvl_prev(lvl_prev_q), .is_output(dir_q),
        .edge_kind(kind_q), .edge_pol(epol_q), .lvl_pol(lpol_q), .trig(trig)
    );

    assign clr_wr = wr_en && (addr == RA_LATCH);

    gpio_flag_latch #(.WIDTH(NPINS)) u_flags (
        .clk(clk), .rst_n(rst_n), .clr_wr(clr_wr), .keep_bits(wdata),
        .trig(trig), .flags(stat_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            dout_q <= '0;
            alt_q  <= '0;
            mask_q <= '1;
            kind_q <= '0;
            epol_q <= '0;
            lpol_q <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_DIR:      dir_q  <= wdata;
                RA_DOUT:     dout_q <= wdata;
                RA_ALTSEL:   alt_q  <= wdata;
                RA_MASK:     mask_q <= wdata;
                RA_TRIGKIND: kind_q <= wdata;
                RA_EDGEPOL:  epol_q <= wdata;
                RA_LVLPOL:   lpol_q <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            RA_DIR:      rdata = dir_q;
            RA_DOUT:     rdata = dout_q;
            RA_PINLVL:   rdata = lvl_sync;
            RA_ALTSEL:   rdata = alt_q;
            RA_MASK:     rdata = mask_q;
            RA_TRIGKIND: rdata = kind_q;
            RA_EDGEPOL:  rdata = epol_q;
            RA_LVLPOL:   rdata = lpol_q;
            RA_LATCH:    rdata = stat_q;
            default:     rdata = '0;
        endcase
    end

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;
    assign alt_sel = alt_q;
    assign irq     = |(stat_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [NPINS-1:0]  wdata,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq,
    input logic [NPINS-1:0]  stat,
    input logic [NPINS-1:0]  dir
);
    // R2
    oe_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_DIR) |=> (pin_oe == $past(wdata)));

    // R9
    mask_all_silences_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_MASK && wdata == '1) |=> !irq);

    // R7
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == RA_LATCH) |=> ((stat & $past(stat)) == $past(stat)));

    // R4
    output_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((stat & ~$past(stat)) & $past(dir)) == '0));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .pin_oe(pin_oe), .irq(irq), .stat(stat_q), .dir(dir_q)
);

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wdata = '0;
    logic [15:0] pin_in = '0;
    logic [15:0] rdata, pin_out, pin_oe, alt_sel;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .alt_sel(alt_sel), .irq(irq)
    );

    // behavioural reference model
    logic [15:0] m_dir, m_out, m_alt, m_mask, m_kind, m_epol, m_lpol, m_stat;
    logic [15:0] m_s1, m_s2, m_s3;

    always @(posedge clk or negedge rst_n) begin
        logic [15:0] hit;
        if (!rst_n) begin
            m_dir = 0; m_out = 0; m_alt = 0; m_mask = 16'hFFFF;
            m_kind = 0; m_epol = 0; m_lpol = 0; m_stat = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            hit = 0;
            for (int i = 0; i < 16; i++) begin
                if (!m_dir[i]) begin
                    if (m_kind[i])
                        hit[i] = m_epol[i] ? (m_s2[i] && !m_s3[i]) : (!m_s2[i] && m_s3[i]);
                    else
                        hit[i] = (m_s2[i] == m_lpol[i]);
                end
            end
            if (wr_en && addr == 8) m_stat = m_stat & wdata;
            m_stat = m_stat | hit;
            if (wr_en) begin
                case (addr)
                    0: m_dir  = wdata;
                    1: m_out  = wdata;
                    3: m_alt  = wdata;
                    4: m_mask = wdata;
                    5: m_kind = wdata;
                    6: m_epol = wdata;
                    7: m_lpol = wdata;
                    default: ;
                endcase
            end
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    function automatic logic [15:0] model_rd(input logic [3:0] a);
        case (a)
            0: return m_dir;
            1: return m_out;
            2: return m_s2;
            3: return m_alt;
            4: return m_mask;
            5: return m_kind;
            6: return m_epol;
            7: return m_lpol;
            8: return m_stat;
            default: return 16'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always begin
        @(posedge clk);
        #5;
        if (!done) begin
            chk("R2 pin_oe", pin_oe, m_dir);
            chk("R2 pin_out", pin_out, m_out);
            chk("R2 alt_sel", alt_sel, m_alt);
            chk("R9 irq", {15'h0, irq}, {15'h0, |(m_stat & ~m_mask)});
            chk("R10 rdata", rdata, model_rd(addr));
        end
    end

    // all tasks start and end at a falling edge and consume one rising edge per cycle
    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
        wr_en = 1'b0; addr = a;
        @(posedge clk);
        #5;
        chk(tag, rdata, exp);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        wr_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1 rst_n = 1'b0;
        @(negedge clk);
        // R1 reset values
        expect_rd(4, 16'hFFFF, "R1 mask reset");
        expect_rd(0, 16'h0000, "R1 dir reset");
        expect_rd(8, 16'h0000, "R1 flags reset");
        expect_rd(6, 16'h0000, "R1 edgepol reset");
        chk("R1 irq reset", {15'h0, irq}, 16'h0);
        rst_n = 1'b1;
        idle(2);

        // switch all pins to rising edges and clear what level-low latched
        bus_write(5, 16'hFFFF);
        bus_write(6, 16'hFFFF);
        bus_write(8, 16'h0000);
        expect_rd(8, 16'h0000, "R7 clear all");

        // R2 pin roles
        bus_write(0, 16'hFF00);
        bus_write(1, 16'hA5A5);
        bus_write(3, 16'h0F0F);
        chk("R2 oe", pin_oe, 16'hFF00);
        chk("R2 out", pin_out, 16'hA5A5);
        chk("R2 alt", alt_sel, 16'h0F0F);
        expect_rd(1, 16'hA5A5, "R2 readback");
        bus_write(4, 16'h0000);
        chk("R9 no flags no irq", {15'h0, irq}, 16'h0);

        // R5 rising edge on input pin 0, R4 output pin 15 toggles too
        pin_in = 16'h8001;
        idle(4);
        expect_rd(8, 16'h0001, "R4/R5 rising latched, output pin ignored");
        chk("R9 irq on unmasked flag", {15'h0, irq}, 16'h1);

        // R3 two-flop latency
        pin_in = 16'h0002;
        expect_rd(2, 16'h8001, "R3 level before sync delay");
        expect_rd(2, 16'h0002, "R3 level after two edges");
        idle(2);
        bus_write(8, 16'h0000);
        expect_rd(8, 16'h0000, "R7 clear after rising");

        // R5 falling edge on pin 1
        bus_write(6, 16'hFFFD);
        pin_in = 16'h0000;
        idle(4);
        expect_rd(8, 16'h0002, "R5 falling latched");
        bus_write(8, 16'h0000);

        // R7 partial clear
        pin_in = 16'h0005;
        idle(4);
        expect_rd(8, 16'h0005, "R5 two rising edges");
        bus_write(8, 16'h0004);
        expect_rd(8, 16'h0004, "R7 write keeps ones clears zeros");

        // R6 level high on pin 2 relatches after clear
        bus_write(5, 16'hFFFB);
        bus_write(7, 16'h0004);
        bus_write(8, 16'h0000);
        expect_rd(8, 16'h0004, "R6 level high relatches");
        bus_write(7, 16'h0000);
        bus_write(8, 16'h0000);
        expect_rd(8, 16'h0000, "R6 level low not met while high");
        pin_in = 16'h0001;
        idle(4);
        expect_rd(8, 16'h0004, "R6 level low latched");
        bus_write(5, 16'hFFFF);
        bus_write(8, 16'h0000);
        expect_rd(8, 16'h0000, "R7 clear back to edge mode");

        // R8 clear racing a fresh rising edge on pin 3
        pin_in = 16'h0009;
        idle(2);
        bus_write(8, 16'h0000);
        expect_rd(8, 16'h0008, "R8 new trigger wins over clear");

        // R9 masking hides but keeps the flag
        bus_write(4, 16'h0008);
        chk("R9 masked flag hidden", {15'h0, irq}, 16'h0);
        expect_rd(8, 16'h0008, "R9 mask keeps flag");
        bus_write(4, 16'h0000);
        chk("R9 unmask shows flag", {15'h0, irq}, 16'h1);

        // R10 read-only and unmapped offsets
        bus_write(2, 16'hFFFF);
        expect_rd(2, 16'h0009, "R10 pin level not writable");
        bus_write(12, 16'hFFFF);
        expect_rd(12, 16'h0000, "R10 unmapped reads zero");
        expect_rd(0, 16'hFF00, "R10 unmapped write ignored");

        // mixed traffic against the model
        for (int k = 0; k < 3000; k++) begin
            pin_in = 16'($urandom);
            if (($urandom % 4) == 0) begin
                bus_write(4'($urandom), 16'($urandom));
            end else begin
                addr = 4'($urandom);
                idle(1);
            end
        end

        idle(1);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule